// File: doc/BRIEF.md
# Page Table Entry Generator

This block fills a run of 64-bit page-table entries into memory without software writing each one. A single start pulse supplies a destination byte address, a starting value, a per-entry step, an OR-mask and an entry count. The block then presents one entry per accepted write on a valid/ready port. Each entry is the mask ORed onto a running arithmetic progression, and each goes to the next 8-byte slot after the previous one.

The count input carries the number of entries minus one, so a zero count still produces a single entry. After the final entry has been accepted, a one-cycle done pulse reports completion. Any start request that arrives while a run is in progress is dropped. The next run can be started in the same cycle that done is high.

Top module: `pte_gen`

## Requirements
- R1: After reset, wr_valid_o, done_o and busy_o are all low.
- R2: A run with count_i = N produces exactly N+1 accepted writes, so count_i = 0 yields one entry.
- R3: Entry i (counting from 0) carries mask | (init + i*incr), computed modulo 2^64.
- R4: Entry i is written at address dest + 8*i, computed modulo 2^ADDR_W.
- R5: The first entry is presented in the cycle after a start is accepted. While wr_ready_i is low, wr_valid_o, wr_addr_o and wr_data_o hold their values, and no entry is skipped or repeated.
- R6: done_o is high for exactly one cycle, the cycle after the final write is accepted. busy_o and wr_valid_o fall at the same time.
- R7: A start pulse seen while busy_o is high is ignored. The entries of the ongoing run are unchanged, and no extra run follows.
- R8: A start pulse is accepted whenever busy_o is low, including the cycle in which done_o is high. The operands are captured at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a new run (taken only when idle) |
| dest_i | input | ADDR_W | Byte address of the first entry |
| init_i | input | 64 | Value of the progression at entry 0 |
| incr_i | input | 64 | Step added per entry |
| mask_i | input | 64 | Bits ORed into every entry |
| count_i | input | CNT_W | Number of entries minus one |
| wr_valid_o | output | 1 | Write request pending |
| wr_ready_i | input | 1 | Memory accepts the pending write |
| wr_addr_o | output | ADDR_W | Byte address of the pending write |
| wr_data_o | output | 64 | Entry value of the pending write |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse after the last write is accepted |

## Verification
The first write request is due one cycle after the edge that accepts the start. Each following entry is due one cycle after the edge at which the previous one is accepted. Done is due one cycle after the final acceptance. The bench drives inputs and samples outputs on the falling edge. It compares the pending write against its own expected entry before it raises ready, and it counts an entry as accepted only when valid and ready were both high across the rising edge. Stalled entries are checked again one cycle later for stability. The done and busy levels are read on the falling edge immediately after the last acceptance.

// File: rtl/pte_gen.sv
module pte_gen #(
  parameter int ADDR_W  = 48,
  parameter int CNT_W   = 14,
  parameter int ENTRY_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  dest_i,
  input  logic [ENTRY_W-1:0] init_i,
  input  logic [ENTRY_W-1:0] incr_i,
  input  logic [ENTRY_W-1:0] mask_i,
  input  logic [CNT_W-1:0]   count_i,
  output logic               wr_valid_o,
  input  logic               wr_ready_i,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [ENTRY_W-1:0] wr_data_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int STRIDE = ENTRY_W / 8;

  logic               busy_q, done_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [ENTRY_W-1:0] acc_q, incr_q, mask_q;
  logic [CNT_W-1:0]   left_q;

  wire fire = busy_q & wr_ready_i;
  wire last = (left_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      acc_q  <= '0;
      incr_q <= '0;
      mask_q <= '0;
      left_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          addr_q <= dest_i;
          acc_q  <= init_i;
          incr_q <= incr_i;
          mask_q <= mask_i;
          left_q <= count_i;
        end
      end else if (fire) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          addr_q <= addr_q + ADDR_W'(STRIDE);
          acc_q  <= acc_q + incr_q;
          left_q <= left_q - 1'b1;
        end
      end
    end
  end

  assign wr_valid_o = busy_q;
  assign wr_addr_o  = addr_q;
  assign wr_data_o  = mask_q | acc_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;

  // checker-only tracking of entries issued in the current run
  logic [CNT_W:0] sent_q;
  logic [CNT_W-1:0] cnt_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sent_q <= '0;
      cnt_q  <= '0;
    end else if (!busy_q && start_i) begin
      sent_q <= '0;
      cnt_q  <= count_i;
    end else if (fire) begin
      sent_q <= sent_q + 1'b1;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !wr_valid_o);
  a_r2_entry_count: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && wr_ready_i && last) |-> (sent_q == {1'b0, cnt_q}));
  a_r3_mask_present: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> ((wr_data_o & mask_q) == mask_q));
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && wr_ready_i && !last) |=> (wr_addr_o == $past(wr_addr_o) + ADDR_W'(STRIDE)));
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(wr_valid_o) && $past(wr_ready_i) && !wr_valid_o));
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i && start_i) |=> $stable(wr_addr_o));
endmodule

// File: tb/pte_gen_tb_top.sv
module pte_gen_tb_top;
  localparam int ADDR_W = 48;
  localparam int CNT_W  = 14;
  localparam int NV     = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] dest_i = '0;
  logic [63:0]       init_i = '0, incr_i = '0, mask_i = '0;
  logic [CNT_W-1:0]  count_i = '0;
  logic              wr_ready_i = 1'b0;
  logic              wr_valid_o, busy_o, done_o;
  logic [ADDR_W-1:0] wr_addr_o;
  logic [63:0]       wr_data_o;

  pte_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ENTRY_W(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dest_i(dest_i),
    .init_i(init_i), .incr_i(incr_i), .mask_i(mask_i), .count_i(count_i),
    .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .busy_o(busy_o), .done_o(done_o));

  localparam logic [ADDR_W-1:0] V_DEST [NV] = '{48'h0000_0000_1000, 48'h0000_0020_0000,
    48'hFFFF_FFFF_FFF0, 48'h0000_0ABC_0000, 48'h0000_0000_0008};
  localparam logic [63:0] V_INIT [NV] = '{64'h1000_0001, 64'h0,
    64'hFFFF_FFFF_FFFF_F000, 64'h5, 64'h0000_0001_0000_0000};
  localparam logic [63:0] V_INCR [NV] = '{64'h1000, 64'h1000, 64'h800,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0020_0000};
  localparam logic [63:0] V_MASK [NV] = '{64'h0, 64'h8000_0000_0000_0067, 64'h3,
    64'h100, 64'hF000_0000_0000_0001};
  localparam logic [CNT_W-1:0] V_CNT [NV] = '{14'd3, 14'd0, 14'd4, 14'd9, 14'd6};
  localparam logic [7:0] V_RDY [NV] = '{8'hFF, 8'hFF, 8'b1010_0110, 8'b0001_0001, 8'b1110_1101};
  localparam logic V_POKE [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input int v);
    int idx = 0, cyc = 0;
    logic [ADDR_W-1:0] ea;
    logic [63:0] ed;
    start_i = 1'b1; dest_i = V_DEST[v]; init_i = V_INIT[v];
    incr_i = V_INCR[v]; mask_i = V_MASK[v]; count_i = V_CNT[v];
    wr_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    chk(wr_valid_o == 1'b1, "R5 first entry one cycle after start", 64'(wr_valid_o), 64'd1);
    while (idx <= int'(V_CNT[v]) && cyc < 400) begin
      ea = V_DEST[v] + ADDR_W'(8 * idx);
      ed = V_MASK[v] | (V_INIT[v] + 64'(idx) * V_INCR[v]);
      chk(wr_valid_o == 1'b1, "R2 entry pending", 64'(wr_valid_o), 64'd1);
      chk(wr_addr_o == ea, "R4 address", 64'(wr_addr_o), 64'(ea));
      chk(wr_data_o == ed, "R3 entry value", wr_data_o, ed);
      wr_ready_i = V_RDY[v][cyc % 8];
      if (V_POKE[v] && idx == 1) begin
        start_i = 1'b1; dest_i = '1; init_i = '1; count_i = '1;
      end
      @(negedge clk);
      start_i = 1'b0;
      if (wr_ready_i) idx++;
      else chk(wr_addr_o == ea && wr_data_o == ed, "R5 hold while stalled", wr_data_o, ed);
      cyc++;
    end
    wr_ready_i = 1'b0;
    chk(idx == int'(V_CNT[v]) + 1, "R2 entry count", 64'(idx), 64'(V_CNT[v]) + 1);
    chk(done_o == 1'b1, "R6 done after last accept", 64'(done_o), 64'd1);
    chk(busy_o == 1'b0 && wr_valid_o == 1'b0, "R6 busy and valid low with done", 64'(busy_o), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!wr_valid_o && !done_o && !busy_o, "R1 reset state", {61'd0, wr_valid_o, done_o, busy_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < NV; v++) run(v);  // R8: each next run starts while done is high
    @(negedge clk);
    chk(done_o == 1'b0, "R6 done is a single pulse", 64'(done_o), 64'd0);
    chk(wr_valid_o == 1'b0, "R7 no extra run after ignored start", 64'(wr_valid_o), 64'd0);
    // R7: start during a stall with ready held low must not move the pending entry
    start_i = 1'b1; dest_i = 48'h100; init_i = 64'h7; incr_i = 64'h1; mask_i = 64'h0; count_i = 14'd1;
    @(negedge clk);
    start_i = 1'b1; dest_i = 48'h900; init_i = 64'h99;
    @(negedge clk);
    start_i = 1'b0;
    chk(wr_addr_o == 48'h100 && wr_data_o == 64'h7, "R7 start while busy ignored", wr_data_o, 64'h7);
    wr_ready_i = 1'b1;
    @(negedge clk);
    chk(wr_addr_o == 48'h108 && wr_data_o == 64'h8, "R7 run continues with captured operands", wr_data_o, 64'h8);
    @(negedge clk);
    wr_ready_i = 1'b0;
    chk(done_o == 1'b1, "R6 done after two entries", 64'(done_o), 64'd1);
    @(negedge clk);
    chk(!wr_valid_o && !busy_o, "R7 idle after run", 64'(busy_o), 64'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule